// File: doc/BRIEF.md
# Dual-Style Subsystem Bus Front End

This block sits between an 8-bit subsystem microprocessor bus and a peripheral register space. It accepts either strobe convention: one with separate active-low read and write strobes, or one with a single active-low data strobe plus a direction line. It also supports two address arrangements. In the multiplexed arrangement, a latch strobe captures the low address byte from the shared data lines, with a ninth address bit on its own pin. In the non-multiplexed arrangement, dedicated lines carry all nine address bits and the shared lines carry only data.

All bus inputs pass through a synchronizer chain of `SYNC_STAGES` flops before use. The block presents the resolved 9-bit address, a one-cycle write pulse with the captured write byte, and a small set of decoded per-target strobes. It also drives read data, with a separate output enable standing in for the tri-state data pins. It decodes a control register, a write-only clock-program register, a write-only modem-control bit-5 location, eight read-only UART shadow bytes, and a FIFO window. The FIFO window is open only while serial bypass is enabled.

Top module: `subsys_bus_if`

## Requirements
- R1: With `busModeSel`=0 and `styleSel`=0, the address {`addrHi`, `dataIn`} follows the bus while `latchStrobe` is high and holds after `latchStrobe` falls. `busAddr` keeps that value while `dataIn` later carries data.
- R2: With `busModeSel`=0 and `styleSel`=1, the address is latched the same way, but the latch is open while `latchStrobe` is low and closes on its rising edge.
- R3: With `busModeSel`=1, `busAddr` equals {`addrHi`, `addrLo`} and pulses on `latchStrobe` have no effect on it.
- R4: With `styleSel`=0, `rdStrobe`=0 with `wrStrobe`=1 is a read cycle, and `rdStrobe`=1 with `wrStrobe`=0 is a write cycle.
- R5: With `styleSel`=1, `rdStrobe` is an active-low data strobe and `wrStrobe` is the direction line. Strobe 0 with direction 1 is a read; strobe 0 with direction 0 is a write.
- R6: Each write cycle yields exactly one single-cycle `busWrEn` pulse after the strobe's trailing edge. `wrData` then holds the byte present on `dataIn` during the strobe.
- R7: Address 272 (decimal) is the control register: a write pulses `ctrlWe`, and a read returns `ctrlRdData`. Address 288 is write-only: a write pulses `clkPgmWe`, and a read returns 0x00.
- R8: Addresses 305 to 312 read byte i = address−305 of `shadowRegs` (bits 8i+7..8i). Byte 0 is divisor low, then interrupt enable, FIFO control, line control, modem control, line status, modem status, and byte 7 is divisor high. Writes to these addresses raise no decoded write strobe.
- R9: Address 304 is write-only: a write pulses `mcr5We` (the new bit is `wrData` bit 5), and a read returns 0x00.
- R10: Address 320 is the FIFO window. With `bypassEn`=1, a write pulses `rxFifoWe`, and a read returns `txFifoData` and pulses `txFifoRe` once after the read ends. With `bypassEn`=0, a read returns 0x00 and neither strobe pulses.
- R11: `dataOe` is 1 only during a read cycle. Otherwise it is 0 and `dataOut` is 0x00.
- R12: A read of an undecoded address returns 0x00, and a write to it raises no decoded write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busModeSel | input | 1 | 0 multiplexed address/data, 1 dedicated address lines |
| styleSel | input | 1 | 0 separate read/write strobes, 1 data strobe plus direction |
| latchStrobe | input | 1 | Address latch strobe (polarity set by styleSel) |
| rdStrobe | input | 1 | Read strobe or data strobe, active low |
| wrStrobe | input | 1 | Write strobe (active low) or direction line (1 = read) |
| addrHi | input | 1 | Address bit 8 |
| addrLo | input | 8 | Dedicated low address bits (non-multiplexed only) |
| dataIn | input | 8 | Shared bus, input side |
| dataOut | output | 8 | Shared bus, output side |
| dataOe | output | 1 | Output enable for the shared bus |
| bypassEn | input | 1 | Serial bypass enabled, opens the FIFO window |
| ctrlRdData | input | 8 | Read value of the control register |
| shadowRegs | input | 64 | Eight UART shadow bytes, byte 0 in the low bits |
| txFifoData | input | 8 | Head of the transmit FIFO |
| busAddr | output | 9 | Resolved internal address |
| busWrEn | output | 1 | One-cycle pulse per completed write |
| wrData | output | 8 | Byte written in the last write cycle |
| ctrlWe | output | 1 | Write pulse, control register |
| clkPgmWe | output | 1 | Write pulse, clock-program register |
| mcr5We | output | 1 | Write pulse, modem-control bit 5 |
| rxFifoWe | output | 1 | Write pulse, receive FIFO |
| txFifoRe | output | 1 | Pop pulse, transmit FIFO |

## Verification
A latch register that closes at the wrong edge, or never closes, shows at `busAddr` within a few clocks. Once the bench moves the shared lines from address to data, `busAddr` follows the data instead of holding. A wrong edge detector or stale write-capture register shows on the first write: `busWrEn` pulses zero or two times, or `wrData` and the decoded strobe disagree with the byte and address just driven. This appears about `SYNC_STAGES`+1 clocks after the strobe is released. Decode and gating faults show as a wrong read byte or a stray strobe in the same access, so each table entry localises them to one address and mode.

// File: rtl/subsys_bus_pkg.sv
package subsys_bus_pkg;

  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int SHADOW_N = 8;
  localparam int SHADOW_IDX_W = $clog2(SHADOW_N);

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 9'd272;
  localparam logic [ADDR_W-1:0] ADR_CLKPGM  = 9'd288;
  localparam logic [ADDR_W-1:0] ADR_MCR5    = 9'd304;
  localparam logic [ADDR_W-1:0] ADR_SHADOW0 = 9'd305;
  localparam logic [ADDR_W-1:0] ADR_FIFO    = 9'd320;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_CLKPGM,
    TGT_MCR5,
    TGT_SHADOW,
    TGT_FIFO
  } target_e;

  typedef struct packed {
    logic latchOpen;
    logic rdActive;
    logic wrActive;
    logic wrPulse;
    logic rdEndPulse;
  } busStrobes_t;

  function automatic target_e decodeTarget(input logic [ADDR_W-1:0] a, input logic byp);
    if (a == ADR_CTRL) return TGT_CTRL;
    if (a == ADR_CLKPGM) return TGT_CLKPGM;
    if (a == ADR_MCR5) return TGT_MCR5;
    if (a >= ADR_SHADOW0 && a < ADR_SHADOW0 + SHADOW_N) return TGT_SHADOW;
    if (a == ADR_FIFO && byp) return TGT_FIFO;
    return TGT_NONE;
  endfunction

endpackage

// File: rtl/subsys_bus_ctrl.sv
module subsys_bus_ctrl
  import subsys_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busModeSel,
  input  logic        styleSel,
  input  logic        latchStrobe,
  input  logic        rdStrobe,
  input  logic        wrStrobe,
  output busStrobes_t strobes
);

  // bit 2 latch, bit 1 read/data strobe, bit 0 write/direction
  logic [2:0] syncChain [SYNC_STAGES];
  logic [2:0] strobeS;
  logic       latchS, rdS, wrS;
  logic       rdActive, wrActive;
  logic       rdPrev, wrPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= 3'b011;
    end else begin
      syncChain[0] <= {latchStrobe, rdStrobe, wrStrobe};
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign strobeS = syncChain[SYNC_STAGES-1];
  assign latchS  = strobeS[2];
  assign rdS     = strobeS[1];
  assign wrS     = strobeS[0];

  // both styles read with low strobe and high second line
  assign rdActive = !rdS && wrS;
  assign wrActive = styleSel ? (!rdS && !wrS) : (rdS && !wrS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdActive;
      wrPrev <= wrActive;
    end
  end

  always_comb begin
    strobes.latchOpen  = !busModeSel && (styleSel ? !latchS : latchS);
    strobes.rdActive   = rdActive;
    strobes.wrActive   = wrActive;
    strobes.wrPulse    = wrPrev && !wrActive;
    strobes.rdEndPulse = rdPrev && !rdActive;
  end

  AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrPulse |=> !strobes.wrPulse); // R6

  AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEndPulse |=> !strobes.rdEndPulse); // R10

endmodule

// File: rtl/subsys_bus_dp.sv
module subsys_bus_dp
  import subsys_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busModeSel,
  input  logic                       bypassEn,
  input  busStrobes_t                strobes,
  input  logic                       addrHi,
  input  logic [DATA_W-1:0]          addrLo,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic [DATA_W-1:0]          ctrlRdData,
  input  logic [SHADOW_N*DATA_W-1:0] shadowRegs,
  input  logic [DATA_W-1:0]          txFifoData,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic [DATA_W-1:0]          wrData,
  output logic                       busWrEn,
  output logic                       ctrlWe,
  output logic                       clkPgmWe,
  output logic                       mcr5We,
  output logic                       rxFifoWe,
  output logic                       txFifoRe
);

  localparam int SYNC_W = 1 + 2 * DATA_W;

  logic [SYNC_W-1:0] syncChain [SYNC_STAGES];
  logic              hiS;
  logic [DATA_W-1:0] loS, dataS;
  logic [ADDR_W-1:0] latchedAddr;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] shadowByte [SHADOW_N];
  logic [ADDR_W-1:0] shadowOff;
  logic [DATA_W-1:0] readValue;
  target_e           rdTarget, wrTarget;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= {addrHi, addrLo, dataIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign {hiS, loS, dataS} = syncChain[SYNC_STAGES-1];

  // transparent address latch for the multiplexed bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchedAddr <= '0;
    else if (strobes.latchOpen) latchedAddr <= {hiS, dataS};
  end

  assign busAddr = busModeSel ? {hiS, loS} : latchedAddr;

  // address and data as they stood during the active phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddr <= '0;
      wrDataQ <= '0;
    end else begin
      if (strobes.rdActive || strobes.wrActive) accAddr <= busAddr;
      if (strobes.wrActive) wrDataQ <= dataS;
    end
  end

  assign wrData  = wrDataQ;
  assign busWrEn = strobes.wrPulse;

  assign wrTarget = decodeTarget(accAddr, bypassEn);
  assign ctrlWe   = strobes.wrPulse && (wrTarget == TGT_CTRL);
  assign clkPgmWe = strobes.wrPulse && (wrTarget == TGT_CLKPGM);
  assign mcr5We   = strobes.wrPulse && (wrTarget == TGT_MCR5);
  assign rxFifoWe = strobes.wrPulse && (wrTarget == TGT_FIFO);
  assign txFifoRe = strobes.rdEndPulse && (wrTarget == TGT_FIFO);

  for (genvar i = 0; i < SHADOW_N; i++) begin : gShadow
    assign shadowByte[i] = shadowRegs[i*DATA_W +: DATA_W];
  end

  assign shadowOff = busAddr - ADR_SHADOW0;
  assign rdTarget  = decodeTarget(busAddr, bypassEn);

  always_comb begin
    unique case (rdTarget)
      TGT_CTRL:   readValue = ctrlRdData;
      TGT_SHADOW: readValue = shadowByte[shadowOff[SHADOW_IDX_W-1:0]];
      TGT_FIFO:   readValue = txFifoData;
      default:    readValue = '0;
    endcase
  end

  assign dataOe  = strobes.rdActive;
  assign dataOut = strobes.rdActive ? readValue : '0;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlWe, clkPgmWe, mcr5We, rxFifoWe, txFifoRe})); // R12

  AST_FIFO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (rxFifoWe || txFifoRe) |-> bypassEn); // R10

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busModeSel && $past(!busModeSel) && !strobes.latchOpen && $past(!strobes.latchOpen))
      |-> $stable(busAddr)); // R1

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe || clkPgmWe || mcr5We || rxFifoWe) |-> $past(strobes.wrActive)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0)); // R11

endmodule

// File: rtl/subsys_bus_if.sv
module subsys_bus_if
  import subsys_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busModeSel,
  input  logic        styleSel,
  input  logic        latchStrobe,
  input  logic        rdStrobe,
  input  logic        wrStrobe,
  input  logic        addrHi,
  input  logic [7:0]  addrLo,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  output logic        dataOe,
  input  logic        bypassEn,
  input  logic [7:0]  ctrlRdData,
  input  logic [63:0] shadowRegs,
  input  logic [7:0]  txFifoData,
  output logic [8:0]  busAddr,
  output logic        busWrEn,
  output logic [7:0]  wrData,
  output logic        ctrlWe,
  output logic        clkPgmWe,
  output logic        mcr5We,
  output logic        rxFifoWe,
  output logic        txFifoRe
);

  busStrobes_t strobes;

  subsys_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .busModeSel  (busModeSel),
    .styleSel    (styleSel),
    .latchStrobe (latchStrobe),
    .rdStrobe    (rdStrobe),
    .wrStrobe    (wrStrobe),
    .strobes     (strobes)
  );

  subsys_bus_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busModeSel (busModeSel),
    .bypassEn   (bypassEn),
    .strobes    (strobes),
    .addrHi     (addrHi),
    .addrLo     (addrLo),
    .dataIn     (dataIn),
    .ctrlRdData (ctrlRdData),
    .shadowRegs (shadowRegs),
    .txFifoData (txFifoData),
    .busAddr    (busAddr),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .wrData     (wrData),
    .busWrEn    (busWrEn),
    .ctrlWe     (ctrlWe),
    .clkPgmWe   (clkPgmWe),
    .mcr5We     (mcr5We),
    .rxFifoWe   (rxFifoWe),
    .txFifoRe   (txFifoRe)
  );

endmodule

// File: tb/subsys_bus_if_tb_top.sv
`timescale 1ns/1ps
module subsys_bus_if_tb_top;

  typedef struct packed {
    logic       bm;    // busModeSel
    logic       zil;   // styleSel
    logic       wr;    // 1 write, 0 read
    logic       byp;   // bypassEn
    logic [8:0] addr;
    logic [7:0] data;
    logic [2:0] sel;   // 0 none,1 ctrl,2 clkpgm,3 mcr5,4 rxfifo,5 txfifo pop
    logic [7:0] exp;   // expected read byte
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 9'd272, 8'hA5, 3'd1, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'd272, 8'h00, 3'd0, 8'h5C},
    '{1'b0, 1'b1, 1'b1, 1'b0, 9'd288, 8'h3C, 3'd2, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd288, 8'h00, 3'd0, 8'h00},
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd305, 8'h00, 3'd0, 8'hA0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'd312, 8'h00, 3'd0, 8'hA7},
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd308, 8'h00, 3'd0, 8'hA3},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd310, 8'h00, 3'd0, 8'hA5},
    '{1'b1, 1'b0, 1'b1, 1'b0, 9'd306, 8'hFF, 3'd0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 9'd304, 8'h20, 3'd3, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'd304, 8'h00, 3'd0, 8'h00},
    '{1'b1, 1'b0, 1'b1, 1'b0, 9'd320, 8'h81, 3'd0, 8'h00},
    '{1'b1, 1'b1, 1'b1, 1'b1, 9'd320, 8'h81, 3'd4, 8'h00},
    '{1'b1, 1'b1, 1'b0, 1'b1, 9'd320, 8'h00, 3'd5, 8'h3E},
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd320, 8'h00, 3'd0, 8'h00},
    '{1'b0, 1'b1, 1'b1, 1'b0, 9'd400, 8'h77, 3'd0, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd511, 8'h00, 3'd0, 8'h00},
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd271, 8'h00, 3'd0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busModeSel = 1'b0, styleSel = 1'b0, latchStrobe = 1'b0;
  logic        rdStrobe = 1'b1, wrStrobe = 1'b1, addrHi = 1'b0, bypassEn = 1'b0;
  logic [7:0]  addrLo = 8'h00, dataIn = 8'h00;
  logic [7:0]  ctrlRdData = 8'h5C, txFifoData = 8'h3E;
  logic [63:0] shadowRegs = 64'hA7A6A5A4A3A2A1A0;
  logic [7:0]  dataOut, wrData;
  logic [8:0]  busAddr;
  logic        dataOe, busWrEn, ctrlWe, clkPgmWe, mcr5We, rxFifoWe, txFifoRe;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int cnt [6];
  logic [7:0] lastWr = 8'h00;
  bit wrLong = 0;

  always #2 clk = ~clk;

  subsys_bus_if dut_i (
    .clk(clk), .rstN(rstN), .busModeSel(busModeSel), .styleSel(styleSel),
    .latchStrobe(latchStrobe), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .addrHi(addrHi), .addrLo(addrLo), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .bypassEn(bypassEn), .ctrlRdData(ctrlRdData),
    .shadowRegs(shadowRegs), .txFifoData(txFifoData), .busAddr(busAddr),
    .busWrEn(busWrEn), .wrData(wrData), .ctrlWe(ctrlWe), .clkPgmWe(clkPgmWe),
    .mcr5We(mcr5We), .rxFifoWe(rxFifoWe), .txFifoRe(txFifoRe)
  );

  initial for (int i = 0; i < 6; i++) cnt[i] = 0;

  always @(posedge clk) begin
    if (busWrEn) begin
      cnt[0] <= cnt[0] + 1;
      lastWr <= wrData;
    end
    if (ctrlWe)   cnt[1] <= cnt[1] + 1;
    if (clkPgmWe) cnt[2] <= cnt[2] + 1;
    if (mcr5We)   cnt[3] <= cnt[3] + 1;
    if (rxFifoWe) cnt[4] <= cnt[4] + 1;
    if (txFifoRe) cnt[5] <= cnt[5] + 1;
  end

  // R6: the write pulse must never last two cycles
  logic busWrEnQ = 1'b0;
  always @(posedge clk) begin
    busWrEnQ <= busWrEn;
    if (busWrEn && busWrEnQ) wrLong <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tagFor(input vec_t v);
    if (v.addr == 9'd272 || v.addr == 9'd288) return "R7";
    if (v.addr == 9'd304) return "R9";
    if (v.addr >= 9'd305 && v.addr <= 9'd312) return "R8";
    if (v.addr == 9'd320) return "R10";
    return "R12";
  endfunction

  function automatic string modeTag(input vec_t v);
    if (v.bm) return "R3";
    return v.zil ? "R2" : "R1";
  endfunction

  task automatic runAccess(input vec_t v);
    int c0 [6];
    logic [7:0] rdv;
    logic oe;
    logic [8:0] seen;
    string strTag;
    strTag = v.zil ? "R5" : "R4";
    rdv = 8'h00;
    oe = 1'b0;
    busModeSel = v.bm;
    styleSel = v.zil;
    bypassEn = v.byp;
    latchStrobe = v.zil;
    rdStrobe = 1'b1;
    wrStrobe = 1'b1;
    idle(3);
    addrHi = v.addr[8];
    if (!v.bm) begin
      dataIn = v.addr[7:0];
      addrLo = ~v.addr[7:0];
      latchStrobe = !v.zil;
      idle(4);
      latchStrobe = v.zil;
      idle(4);
    end else begin
      addrLo = v.addr[7:0];
      idle(4);
    end
    dataIn = v.wr ? v.data : 8'hEE;
    for (int i = 0; i < 6; i++) c0[i] = cnt[i];
    if (v.wr) begin
      wrStrobe = 1'b0;
      rdStrobe = v.zil ? 1'b0 : 1'b1;
      idle(5);
      seen = busAddr;
      rdStrobe = 1'b1;
      wrStrobe = 1'b1;
      idle(5);
    end else begin
      rdStrobe = 1'b0;
      wrStrobe = 1'b1;
      idle(5);
      seen = busAddr;
      rdv = dataOut;
      oe = dataOe;
      rdStrobe = 1'b1;
      idle(5);
    end
    chk(seen == v.addr, modeTag(v), "busAddr", int'(seen), int'(v.addr));
    if (v.wr) begin
      chk(cnt[0] - c0[0] == 1, {"R6 ", strTag}, "write pulses", cnt[0] - c0[0], 1);
      for (int s = 1; s < 6; s++)
        chk((cnt[s] - c0[s]) == ((int'(v.sel) == s) ? 1 : 0), tagFor(v), "strobe count",
            cnt[s] - c0[s], (int'(v.sel) == s) ? 1 : 0);
      chk(lastWr == v.data, "R6", "wrData", int'(lastWr), int'(v.data));
    end else begin
      chk(oe == 1'b1, {"R11 ", strTag}, "dataOe during read", int'(oe), 1);
      chk(rdv == v.exp, tagFor(v), "read byte", int'(rdv), int'(v.exp));
      chk(cnt[0] == c0[0], strTag, "no write on read", cnt[0] - c0[0], 0);
      chk((cnt[5] - c0[5]) == ((v.sel == 3'd5) ? 1 : 0), "R10", "tx pop count",
          cnt[5] - c0[5], (v.sel == 3'd5) ? 1 : 0);
    end
    chk(dataOe == 1'b0 && dataOut == 8'h00, "R11", "idle bus", int'({dataOe, dataOut}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk(busAddr == 9'd0, "R11", "reset busAddr", int'(busAddr), 0);
    chk(dataOe == 1'b0, "R11", "reset dataOe", int'(dataOe), 0);
    chk({busWrEn, ctrlWe, clkPgmWe, mcr5We, rxFifoWe, txFifoRe} == 6'd0, "R6",
        "reset strobes", int'({busWrEn, ctrlWe, clkPgmWe, mcr5We, rxFifoWe, txFifoRe}), 0);
    rstN = 1'b1;
    idle(3);

    for (int i = 0; i < NV; i++) runAccess(VECS[i]);

    // R3: latch strobe ignored with dedicated address lines
    busModeSel = 1'b1;
    styleSel = 1'b0;
    addrHi = 1'b1;
    addrLo = 8'h23;
    dataIn = 8'h55;
    idle(4);
    latchStrobe = 1'b1;
    idle(4);
    chk(busAddr == 9'h123, "R3", "addr with latch high", int'(busAddr), 'h123);
    latchStrobe = 1'b0;
    idle(4);
    chk(busAddr == 9'h123, "R3", "addr after latch pulse", int'(busAddr), 'h123);

    // R1: multiplexed latch holds after strobe drops, data lines move
    busModeSel = 1'b0;
    dataIn = 8'h10;
    addrHi = 1'b1;
    latchStrobe = 1'b1;
    idle(4);
    latchStrobe = 1'b0;
    idle(4);
    dataIn = 8'hC3;
    addrHi = 1'b0;
    idle(4);
    chk(busAddr == 9'h110, "R1", "latched addr held", int'(busAddr), 'h110);

    chk(wrLong == 1'b0, "R6", "pulse width over one cycle", int'(wrLong), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule